// File: doc/BRIEF.md
# Fractional 32.768 kHz Timing-Clock Divider

This block turns a 24 MHz reference clock into a 32.768 kHz timing signal for timers and input debounce logic. The ratio between the two frequencies is not an integer (732.421875), so the block does not count a fixed number of cycles. It uses a phase accumulator instead. Each reference cycle adds a fixed increment to the accumulator. Whenever the sum reaches the modulus, the modulus is subtracted and the square-wave output changes level. Over a long window the average ratio is exact. The time between any two output edges differs by at most one reference cycle.

A single select bit changes the modulus. This keeps the output at 32.768 kHz when the low-power operating point halves the reference to 12 MHz, which gives a ratio of 366.2109375. Besides the square wave, the block gives a one-cycle enable pulse on every rising edge of the output. Downstream logic can then run on the reference clock and use the pulse as a clock enable.

The increment and the two moduli are parameters. Their defaults are 65536, 24,000,000 and 12,000,000. The parameters assume that the increment is smaller than both moduli.

Top module: `frac32k_divider`

## Requirements
- R1: While reset is low at a clock edge, the block drives both `sq_out` and `tick_en` low at that edge and clears the accumulator to zero.
- R2: With `ratio_sel` = 0 (modulus MOD0), any window of MOD0 consecutive reference cycles contains exactly INC/2 rising edges of `sq_out`.
- R3: With `ratio_sel` = 1 (modulus MOD1), any window of MOD1 consecutive reference cycles contains exactly INC/2 rising edges of `sq_out`.
- R4: In steady state the number of cycles between consecutive toggles of `sq_out` is either floor(MOD/INC) or ceil(MOD/INC), where MOD is the active modulus.
- R5: `tick_en` is high for exactly one cycle, in the same cycle that `sq_out` first reads high after a rising edge, and at no other time.
- R6: Starting from reset with a cleared accumulator, the first rising edge of `sq_out` occurs at the clock edge ceil(MOD/INC) after reset is released.
- R7: When `ratio_sel` changes and the accumulator is below the new modulus, the accumulator value is kept. The first wrap then occurs after the accumulator has gained the remaining distance to the new modulus.
- R8: When `ratio_sel` changes and the accumulator is at or above the new modulus, the new modulus is subtracted once, and that reduction does not toggle the output. The accumulator never holds a value at or above the modulus it was last updated with.
- R9: With the default parameters, the toggle spacing is 366 or 367 cycles in mode 0 and 183 or 184 cycles in mode 1.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock (24 MHz or 12 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_sel | input | 1 | Modulus select: 0 = MOD0 (24 MHz), 1 = MOD1 (12 MHz) |
| tick_en | output | 1 | One-cycle pulse on each rising edge of `sq_out` |
| sq_out | output | 1 | 32.768 kHz square wave |

## Verification
The main function is tried with both values of the select bit on a reduced instance (INC 64, moduli 2400 and 1200). That instance has half-step ratios of 37.5 and 18.75, so the rise count over a full-modulus window tells an exact fractional ratio apart from a truncated or rounded integer one. The windows start at uneven offsets to show that the count holds in every window, not only the first. Mode switches are made at accumulator values below and above the new modulus. The two cases separate keeping the value, subtracting once, and wrongly toggling on the reduction. A second instance with the default parameters shows the real 24 MHz and 12 MHz edge spacings.

// File: rtl/frac32k_pkg.sv
// Package: shared mode type and width helpers for the fractional divider.
// Assumes moduli and the increment fit in 31 bits.
package frac32k_pkg;

    typedef enum logic {
        MODE_FULL = 1'b0,   // reference at full rate, modulus MOD0
        MODE_HALF = 1'b1    // reference halved, modulus MOD1
    } ratio_mode_e;

    // Width that holds the sum of a value below the larger modulus plus the increment.
    function automatic int acc_width(input int mod_a, input int mod_b);
        int m;
        m = (mod_a > mod_b) ? mod_a : mod_b;
        return $clog2(2 * m + 1);
    endfunction

    // Largest toggle spacing, in cycles, for the given modulus and increment.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/frac32k_modulus.sv
// Modulus selector: maps the ratio-select bit onto the active modulus.
// Assumes both moduli fit in ACC_W bits; purely combinational.
module frac32k_modulus
    import frac32k_pkg::*;
#(
    parameter int MOD0  = 24000000,
    parameter int MOD1  = 12000000,
    parameter int ACC_W = 26
) (
    input  logic             sel,
    output logic [ACC_W-1:0] mod_cur
);

    localparam logic [ACC_W-1:0] MOD0_V = ACC_W'(MOD0);
    localparam logic [ACC_W-1:0] MOD1_V = ACC_W'(MOD1);

    ratio_mode_e mode;

    // Decode the select bit into a mode and pick its modulus.
    always_comb begin
        mode    = ratio_mode_e'(sel);
        mod_cur = (mode == MODE_HALF) ? MOD1_V : MOD0_V;
    end

endmodule

// File: rtl/frac32k_accum.sv
// Phase accumulator: adds INC every cycle and wraps at the active modulus.
// If the modulus shrinks below the stored phase, the phase is first reduced
// by one modulus (without a wrap), then advanced. Assumes INC < both moduli.
module frac32k_accum #(
    parameter int INC   = 65536,
    parameter int MOD0  = 24000000,
    parameter int MOD1  = 12000000,
    parameter int ACC_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic [ACC_W-1:0] mod_cur,
    output logic             wrap
);

    localparam logic [ACC_W-1:0] INC_V  = ACC_W'(INC);
    localparam logic [ACC_W-1:0] MOD0_V = ACC_W'(MOD0);
    localparam logic [ACC_W-1:0] MOD1_V = ACC_W'(MOD1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] sum;
    logic             sel_q;

    // Reduce the stored phase into range, add the increment, detect the wrap.
    always_comb begin
        base  = (acc_q >= mod_cur) ? (acc_q - mod_cur) : acc_q;
        sum   = base + INC_V;
        wrap  = (sum >= mod_cur);
        acc_d = wrap ? (sum - mod_cur) : sum;
    end

    // Phase register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            sel_q <= 1'b0;
        end else begin
            acc_q <= acc_d;
            sel_q <= sel;
        end
    end

    // R8: stored phase stays below the modulus it was last updated with.
    a_r8_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < (sel_q ? MOD1_V : MOD0_V))
        else $error("accumulator out of range");

endmodule

// File: rtl/frac32k_output.sv
// Output stage: toggles the square wave on each wrap and raises a one-cycle
// enable on each rising transition. Also holds a spacing monitor for the
// fractional jitter bound. Assumes at most one wrap per cycle.
module frac32k_output #(
    parameter int INC  = 65536,
    parameter int MOD0 = 24000000,
    parameter int MOD1 = 12000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic wrap,
    output logic sq_out,
    output logic tick_en
);

    localparam int LO0   = MOD0 / INC;
    localparam int HI0   = frac32k_pkg::ceil_div(MOD0, INC);
    localparam int LO1   = MOD1 / INC;
    localparam int HI1   = frac32k_pkg::ceil_div(MOD1, INC);
    localparam int HIMAX = (HI0 > HI1) ? HI0 : HI1;
    localparam int CNT_W = $clog2(HIMAX + 2);

    logic             sq_q;
    logic             en_q;
    logic [CNT_W-1:0] gap_q;
    logic             skip_q;
    logic             sel_q;

    // Square-wave toggle and rising-edge enable, both registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= 1'b0;
            en_q <= 1'b0;
        end else begin
            sq_q <= sq_q ^ wrap;
            en_q <= wrap & ~sq_q;
        end
    end

    // Monitor state: cycles since last wrap, and whether a mode change intervened.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            skip_q <= 1'b0;
            sel_q  <= 1'b0;
        end else begin
            sel_q <= sel;
            if (wrap) begin
                gap_q  <= '0;
                skip_q <= 1'b0;
            end else begin
                if (gap_q != {CNT_W{1'b1}}) gap_q <= gap_q + 1'b1;
                if (sel != sel_q) skip_q <= 1'b1;
            end
        end
    end

    assign sq_out  = sq_q;
    assign tick_en = en_q;

    // R5: enable never lasts two cycles.
    a_r5_en_single: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> !en_q)
        else $error("enable longer than one cycle");

    // R5: enable only accompanies a fresh rising output edge.
    a_r5_en_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> (sq_q && !$past(sq_q)))
        else $error("enable without rising edge");

    // R4: wrap spacing within one cycle of the exact ratio (mode 0).
    a_r4_spacing_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !skip_q && sel == sel_q && !sel) |->
            (32'(gap_q) + 1 >= LO0 && 32'(gap_q) + 1 <= HI0))
        else $error("mode 0 spacing out of bound");

    // R4: wrap spacing within one cycle of the exact ratio (mode 1).
    a_r4_spacing_half: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !skip_q && sel == sel_q && sel) |->
            (32'(gap_q) + 1 >= LO1 && 32'(gap_q) + 1 <= HI1))
        else $error("mode 1 spacing out of bound");

endmodule

// File: rtl/frac32k_divider.sv
// Top: fractional divider from a 24/12 MHz reference to 32.768 kHz.
// Chains modulus select, phase accumulator and output stage.
// Assumes ratio_sel is synchronous to clk_ref and INC < MOD1, INC < MOD0.
module frac32k_divider #(
    parameter int INC  = 65536,
    parameter int MOD0 = 24000000,
    parameter int MOD1 = 12000000
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic ratio_sel,
    output logic tick_en,
    output logic sq_out
);

    localparam int ACC_W = frac32k_pkg::acc_width(MOD0, MOD1);

    logic [ACC_W-1:0] mod_cur;
    logic             wrap;

    frac32k_modulus #(.MOD0(MOD0), .MOD1(MOD1), .ACC_W(ACC_W)) u_mod (
        .sel     (ratio_sel),
        .mod_cur (mod_cur)
    );

    frac32k_accum #(.INC(INC), .MOD0(MOD0), .MOD1(MOD1), .ACC_W(ACC_W)) u_acc (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .sel     (ratio_sel),
        .mod_cur (mod_cur),
        .wrap    (wrap)
    );

    frac32k_output #(.INC(INC), .MOD0(MOD0), .MOD1(MOD1)) u_out (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .sel     (ratio_sel),
        .wrap    (wrap),
        .sq_out  (sq_out),
        .tick_en (tick_en)
    );

endmodule

// File: tb/tb_frac32k_divider.sv
// Directed bench: a reduced instance (INC 64, moduli 2400/1200) for exact
// window counts and mode switches, plus a default instance for real spacing.
module tb_frac32k_divider;

    localparam int CLK_PERIOD = 10;
    localparam int S_INC  = 64;
    localparam int S_MOD0 = 2400;
    localparam int S_MOD1 = 1200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_s = 1'b0;
    logic sel_n = 1'b0;
    logic en_s, sq_s, en_n, sq_n;
    int   n_tests = 0;
    int   n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    frac32k_divider #(.INC(S_INC), .MOD0(S_MOD0), .MOD1(S_MOD1)) dut (
        .clk_ref (clk), .rst_n (rst_n), .ratio_sel (sel_s),
        .tick_en (en_s), .sq_out (sq_s)
    );

    frac32k_divider dut_nom (
        .clk_ref (clk), .rst_n (rst_n), .ratio_sel (sel_n),
        .tick_en (en_n), .sq_out (sq_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Reset both instances with the given selects, release at a negedge.
    task automatic do_reset(input logic s_small, input logic s_nom);
        rst_n = 1'b0;
        sel_s = s_small;
        sel_n = s_nom;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    // R1: outputs low while reset is held.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        check(sq_s == 1'b0, "R1 sq_out in reset", int'(sq_s), 0);
        check(en_s == 1'b0, "R1 tick_en in reset", int'(en_s), 0);
        check(sq_n == 1'b0, "R1 default sq_out in reset", int'(sq_n), 0);
    endtask

    // Ticks after reset until sq_s first reads high.
    task automatic first_rise(output int at);
        at = -1;
        for (int k = 1; k <= 5000; k++) begin
            tick();
            if (sq_s) begin
                at = k;
                break;
            end
        end
    endtask

    // R6: first rising edge from a cleared accumulator.
    task automatic t_first_edge(input logic s, input int exp);
        int at;
        do_reset(s, 1'b0);
        first_rise(at);
        check(at == exp, "R6 first rising edge", at, exp);
    endtask

    // R2/R3/R5: rising-edge and enable counts over a window.
    task automatic t_window(input logic s, input int offset, input int win,
                            input int exp, input string req);
        int rises = 0, ens = 0, bad = 0;
        logic prev;
        do_reset(s, 1'b0);
        repeat (offset) tick();
        prev = sq_s;
        for (int k = 0; k < win; k++) begin
            tick();
            if (sq_s && !prev) rises++;
            if (en_s) ens++;
            if (en_s != (sq_s && !prev)) bad++;
            prev = sq_s;
        end
        check(rises == exp, req, rises, exp);
        check(ens == exp, "R5 enable count equals rises", ens, exp);
        check(bad == 0, "R5 enable aligned with rise", bad, 0);
    endtask

    // R4/R9: min and max toggle spacing over a stretch; sig picks instance.
    task automatic t_spacing(input bit nom, input logic s, input int ticks,
                             input int lo, input int hi, input string req);
        int mn = 1 << 30, mx = 0, cnt = 0;
        bit have = 0;
        logic prev, cur;
        do_reset(nom ? 1'b0 : s, nom ? s : 1'b0);
        prev = nom ? sq_n : sq_s;
        for (int k = 0; k < ticks; k++) begin
            tick();
            cnt++;
            cur = nom ? sq_n : sq_s;
            if (cur != prev) begin
                if (have) begin
                    if (cnt < mn) mn = cnt;
                    if (cnt > mx) mx = cnt;
                end
                have = 1;
                cnt = 0;
            end
            prev = cur;
        end
        check(mn == lo, {req, " min spacing"}, mn, lo);
        check(mx == hi, {req, " max spacing"}, mx, hi);
    endtask

    // R7/R8: switch the select after n ticks, expect first rise at tick exp.
    task automatic t_switch(input logic s0, input int n, input int exp, input string req);
        int at = -1;
        bit early = 0;
        do_reset(s0, 1'b0);
        for (int k = 1; k <= n; k++) begin
            tick();
            if (sq_s) early = 1;
        end
        sel_s = ~s0;
        for (int k = n + 1; k <= 5000; k++) begin
            tick();
            if (sq_s) begin
                at = k;
                break;
            end
        end
        check(!early, {req, " no edge before switch"}, int'(early), 0);
        check(at == exp, req, at, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_first_edge(1'b0, 38);                          // R6: ceil(2400/64)
        t_first_edge(1'b1, 19);                          // R6: ceil(1200/64)
        t_window(1'b0, 0,   S_MOD0, S_INC / 2, "R2 rises in mode 0 window");
        t_window(1'b0, 777, S_MOD0, S_INC / 2, "R2 rises in offset mode 0 window");
        t_window(1'b1, 0,   S_MOD1, S_INC / 2, "R3 rises in mode 1 window");
        t_window(1'b1, 413, S_MOD1, S_INC / 2, "R3 rises in offset mode 1 window");
        t_spacing(1'b0, 1'b0, 3000, 37, 38, "R4 mode 0");
        t_spacing(1'b0, 1'b1, 3000, 18, 19, "R4 mode 1");
        t_switch(1'b0, 10, 19, "R7 switch 0->1 phase kept");     // 640 < 1200
        t_switch(1'b1, 10, 38, "R7 switch 1->0 phase kept");     // 640 < 2400
        t_switch(1'b0, 20, 38, "R8 switch 0->1 phase reduced");  // 1280 -> 80
        t_spacing(1'b1, 1'b0, 5000, 366, 367, "R9 default mode 0");
        t_spacing(1'b1, 1'b1, 3000, 183, 184, "R9 default mode 1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule